// File: doc/BRIEF.md
# Multi-Lane Serial ADC Reader

This block reads a group of identical 12-bit serial-output analog-to-digital converters. All converters share one active-low chip select and one serial clock, and each one returns its result on its own data line. The reader runs from a fast system clock and divides it down to make the serial clock. It frames each conversion by pulling chip select low for sixteen serial clock cycles and captures every lane in parallel on the rising serial clock edges.

A converter frame carries four leading bits ahead of the twelve data bits. The reader throws those leading bits away and keeps the twelve that follow, most significant bit first. When a frame ends, it releases chip select, places one 12-bit word per lane on a flat output bus, and raises a one-cycle ready strobe. The start input sets the conversion rate: each request starts one frame. If a request arrives while a frame is running or while the bus is still quiet after a frame, it is remembered and served as soon as the quiet time has passed. Chip select always stays high for a minimum quiet time between frames.

Top module: `adc_lane_reader`

## Requirements
- R1: A synchronous active-low reset forces cs_n high, sclk high, ready low and every output word to zero, and drops any remembered start request.
- R2: A start request seen while idle pulls cs_n low on the next clock edge. cs_n then stays low for exactly 33*HALF_PERIOD system cycles (165 by default), and sclk makes exactly 16 rising edges in that time.
- R3: sclk has a period of 2*HALF_PERIOD system cycles (10 by default, which gives 20 MHz from a 200 MHz clock). Each frame begins with a falling edge, and sclk is high whenever cs_n is high.
- R4: Each lane's sdi bit is sampled on the rising sclk edges. Of the 16 bits in a frame, the first 4 are discarded whatever their value. The remaining 12 form the sample, with the first received bit stored as bit 11.
- R5: Lane k's sample appears on dout[12k+11:12k]. Lanes are captured in parallel and do not affect one another.
- R6: ready is high for exactly one system cycle per frame: the cycle in which cs_n has just returned high and dout has just taken the new samples.
- R7: dout holds its value at all times except in the cycle where ready is high.
- R8: Between the end of one frame and the start of the next, cs_n stays high for at least QUIET_CYC system cycles (10 by default, which is 50 ns).
- R9: A start request made during a frame or during the quiet time is held and starts exactly one further frame once the quiet time has passed. Several such requests merge into one.
- R10: With no start request, no frame begins and dout does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Conversion request, sampled on each clock edge |
| sdi | input | LANES | Serial data, one line per converter |
| cs_n | output | 1 | Shared active-low chip select |
| sclk | output | 1 | Shared serial clock, idles high |
| dout | output | LANES*SAMPLE_W | Latest sample of every lane, lane 0 in the low bits |
| ready | output | 1 | One-cycle strobe marking new samples on dout |

## Verification
The converter model in the bench puts ones into the leading bits of some frames. A reader that kept the wrong window of the sixteen bits, or sampled on the falling edge, would then return shifted or corrupted words. The bench sends start requests in the middle of a frame and again during the quiet time. A reader that dropped those requests would never start the second frame, and one that counted each request separately would run an extra frame. It also measures how long chip select stays low and high and counts the sclk rising edges, so an off-by-one in the edge or quiet counters changes a measured count. Finally, it resets the reader in the middle of a frame and checks that no stale completion or remembered request follows.

// File: rtl/adc_rd_pkg.sv
// Package: shared types and helpers for the serial ADC reader.
// Assumes: nothing beyond IEEE 1800-2017.
package adc_rd_pkg;

    // Frame sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAME = 2'd1,
        ST_QUIET = 2'd2
    } rd_state_e;

    // Counter width able to hold values 0..n, never below one bit.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/adc_rd_tick.sv
// Module: half-period tick generator for the serial clock.
// Raises tick once every HALF system cycles while run is high, and
// restarts its count whenever run is low.
// Assumes: HALF >= 1.
module adc_rd_tick #(
    parameter int unsigned HALF = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    import adc_rd_pkg::*;

    localparam int unsigned CW = cnt_width(HALF);
    localparam logic [CW-1:0] CLAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    // Purpose: count system cycles within one sclk half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == CLAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == CLAST);

    // R3: two ticks are always HALF cycles apart, so no tick follows another unless HALF is 1
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && HALF > 1) |=> !tick);

endmodule

// File: rtl/adc_rd_seq.sv
// Module: frame sequencer. Drives the shared chip select and serial clock,
// tells the lanes when to shift and when to copy out, enforces the quiet
// time, and remembers start requests that arrive while busy.
// Assumes: tick comes from adc_rd_tick driven by this module's run output.
module adc_rd_seq #(
    parameter int unsigned FRAME_BITS = 16,
    parameter int unsigned LEAD_BITS  = 4,
    parameter int unsigned QUIET_CYC  = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic run,
    output logic cs_n,
    output logic sclk,
    output logic shift_en,
    output logic frame_end
);
    import adc_rd_pkg::*;

    // One edge index per sclk half period, plus one closing half period.
    localparam int unsigned  EW     = cnt_width(2 * FRAME_BITS);
    localparam logic [EW-1:0] LAST_E = EW'(2 * FRAME_BITS);
    localparam logic [EW-1:0] LEAD_E = EW'(2 * LEAD_BITS);
    localparam int unsigned  QW     = cnt_width(QUIET_CYC);
    localparam logic [QW-1:0] QLAST  = QW'((QUIET_CYC > 0) ? QUIET_CYC - 1 : 0);

    rd_state_e     state;
    logic [EW-1:0] ecnt;
    logic [QW-1:0] qcnt;
    logic          pend;
    logic          cs_n_q;
    logic          sclk_q;

    assign run       = (state == ST_FRAME);
    assign frame_end = run && tick && (ecnt == LAST_E);
    // R4: odd edge indexes are rising sclk edges; keep only those past the lead bits
    assign shift_en  = run && tick && ecnt[0] && (ecnt > LEAD_E);
    assign cs_n      = cs_n_q;
    assign sclk      = sclk_q;

    // Purpose: step through idle, frame and quiet, and drive cs_n and sclk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            ecnt   <= '0;
            qcnt   <= '0;
            pend   <= 1'b0;
            cs_n_q <= 1'b1;
            sclk_q <= 1'b1;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start || pend) begin
                        state  <= ST_FRAME;
                        cs_n_q <= 1'b0;
                        ecnt   <= '0;
                        pend   <= 1'b0;
                    end
                end
                ST_FRAME: begin
                    if (start) begin
                        pend <= 1'b1;
                    end
                    if (tick) begin
                        if (ecnt == LAST_E) begin
                            cs_n_q <= 1'b1;
                            qcnt   <= '0;
                            state  <= ST_QUIET;
                        end else begin
                            sclk_q <= ecnt[0];
                            ecnt   <= ecnt + 1'b1;
                        end
                    end
                end
                ST_QUIET: begin
                    if (start) begin
                        pend <= 1'b1;
                    end
                    if (qcnt == QLAST) begin
                        state <= ST_IDLE;
                    end else begin
                        qcnt <= qcnt + 1'b1;
                    end
                end
                default: begin
                    state  <= ST_IDLE;
                    cs_n_q <= 1'b1;
                    sclk_q <= 1'b1;
                end
            endcase
        end
    end

    // Purpose (check only): count cs_n high cycles and sclk rising edges per frame.
    logic [15:0] hi_cnt;
    logic [7:0]  rise_cnt;
    logic        sclk_d;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt   <= 16'(QUIET_CYC);
            rise_cnt <= '0;
            sclk_d   <= 1'b1;
        end else begin
            sclk_d <= sclk_q;
            if (!cs_n_q) begin
                hi_cnt <= '0;
            end else if (hi_cnt != 16'hFFFF) begin
                hi_cnt <= hi_cnt + 1'b1;
            end
            if (cs_n_q) begin
                rise_cnt <= '0;
            end else if (sclk_q && !sclk_d) begin
                rise_cnt <= rise_cnt + 1'b1;
            end
        end
    end

    // R3: sclk idles high whenever chip select is inactive
    a_r3_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_q |-> sclk_q);

    // R8: chip select was high for at least the quiet time before it falls
    a_r8_quiet_time: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_q) |-> ($past(hi_cnt) >= 16'(QUIET_CYC)));

    // R2: every frame carries exactly FRAME_BITS rising sclk edges
    a_r2_edge_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_q) |-> (rise_cnt == 8'(FRAME_BITS)));

    // R9: a request during a busy phase is remembered until a frame starts
    a_r9_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state != ST_IDLE) |=> pend);

endmodule

// File: rtl/adc_rd_lane.sv
// Module: one converter lane. Shifts in the kept data bits MSB first and
// copies them to the output word when the frame ends.
// Assumes: shift_en pulses exactly SAMPLE_W times per frame, on rising sclk.
module adc_rd_lane #(
    parameter int unsigned SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sdi,
    input  logic                shift_en,
    input  logic                load,
    output logic [SAMPLE_W-1:0] dout
);
    logic [SAMPLE_W-1:0] shreg;

    // Purpose: capture serial bits and publish the finished word (R4).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            dout  <= '0;
        end else begin
            if (shift_en) begin
                shreg <= {shreg[SAMPLE_W-2:0], sdi};
            end
            if (load) begin
                dout <= shreg;
            end
        end
    end

    // R4: the shift and the copy-out never fall in the same cycle
    a_r4_no_shift_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !shift_en);

endmodule

// File: rtl/adc_lane_reader.sv
// Module: top of the multi-lane serial ADC reader. Ties the tick generator,
// the frame sequencer and one capture lane per converter together.
// Assumes: all converters share cs_n and sclk and change sdi after a
// falling sclk edge; FRAME_BITS > SAMPLE_W >= 2.
module adc_lane_reader #(
    parameter int unsigned LANES       = 2,
    parameter int unsigned SAMPLE_W    = 12,
    parameter int unsigned FRAME_BITS  = 16,
    parameter int unsigned HALF_PERIOD = 5,
    parameter int unsigned QUIET_CYC   = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [LANES-1:0]          sdi,
    output logic                      cs_n,
    output logic                      sclk,
    output logic [LANES*SAMPLE_W-1:0] dout,
    output logic                      ready
);
    localparam int unsigned LEAD_BITS = FRAME_BITS - SAMPLE_W;

    logic run;
    logic tick;
    logic shift_en;
    logic frame_end;

    adc_rd_tick #(
        .HALF (HALF_PERIOD)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    adc_rd_seq #(
        .FRAME_BITS (FRAME_BITS),
        .LEAD_BITS  (LEAD_BITS),
        .QUIET_CYC  (QUIET_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .tick      (tick),
        .run       (run),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .shift_en  (shift_en),
        .frame_end (frame_end)
    );

    // R5: one independent capture lane per converter
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        adc_rd_lane #(
            .SAMPLE_W (SAMPLE_W)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .sdi      (sdi[k]),
            .shift_en (shift_en),
            .load     (frame_end),
            .dout     (dout[k*SAMPLE_W +: SAMPLE_W])
        );
    end

    // Purpose: register the frame-end strobe so ready lines up with dout (R6).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready <= 1'b0;
        end else begin
            ready <= frame_end;
        end
    end

    // R6: ready lasts a single cycle
    a_r6_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    // R6: ready comes with chip select just released
    a_r6_ready_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (cs_n && $past(!cs_n)));

    // R7: outputs change only together with ready
    a_r7_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> $stable(dout));

endmodule

// File: tb/adc_lane_reader_tb.sv
module adc_lane_reader_tb;
    localparam int LANES = 2;
    localparam int SW    = 12;
    localparam int HALF  = 5;
    localparam int QUIET = 10;
    localparam int FRAME_LOW = 33 * HALF;

    // Entry: {lead bits[27:24], lane1 sample[23:12], lane0 sample[11:0]}
    localparam logic [27:0] VEC [6] = '{
        {4'h0, 12'h000, 12'hFFF},
        {4'h0, 12'hA5A, 12'h5A5},
        {4'hF, 12'h001, 12'h800},
        {4'h0, 12'h123, 12'h456},
        {4'h9, 12'hFFF, 12'h000},
        {4'h0, 12'h7FE, 12'h801}
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [LANES-1:0]     sdi = '0;
    logic                 cs_n;
    logic                 sclk;
    logic [LANES*SW-1:0]  dout;
    logic                 ready;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    adc_lane_reader u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .sdi   (sdi),
        .cs_n  (cs_n),
        .sclk  (sclk),
        .dout  (dout),
        .ready (ready)
    );

    // Converter model: one bit out per falling sclk edge, MSB first.
    logic [15:0] word [LANES];
    int bidx = 15;
    always @(negedge cs_n) bidx = 15;
    always @(negedge sclk) begin
        if (cs_n === 1'b0 && bidx >= 0) begin
            for (int l = 0; l < LANES; l++) sdi[l] <= word[l][bidx];
            bidx = bidx - 1;
        end
    end

    // Monitor: cs_n low/high run lengths, frame count and sclk rising edges.
    int low_run = 0, hi_run = 0, last_low = 0, last_hi = 0, frames = 0;
    int rise_run = 0, last_rises = 0;
    always @(posedge sclk) if (cs_n === 1'b0) rise_run++;
    always @(negedge clk) begin
        if (cs_n === 1'b0) begin
            if (hi_run > 0) last_hi = hi_run;
            if (low_run == 0) rise_run = 0;
            hi_run = 0;
            low_run++;
        end else if (cs_n === 1'b1) begin
            if (low_run > 0) begin
                last_low = low_run;
                last_rises = rise_run;
                frames++;
            end
            low_run = 0;
            hi_run++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_words(input logic [27:0] v);
        word[0] = {v[27:24], v[11:0]};
        word[1] = {v[27:24], v[23:12]};
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_ready(input string req);
        int n = 0;
        while (ready !== 1'b1 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 2000) chk(req, 32'd0, 32'd1);
    endtask

    initial begin
        logic [23:0] held;
        int f0;
        set_words(28'h0);
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 cs_n in reset", 32'(cs_n), 32'd1);
        chk("R1 sclk in reset", 32'(sclk), 32'd1);
        chk("R1 ready in reset", 32'(ready), 32'd0);
        chk("R1 dout in reset", 32'(dout), 32'd0);
        rst_n = 1'b1;

        // R10: no start, no frame
        f0 = frames;
        repeat (60) @(negedge clk);
        chk("R10 no frame without start", 32'(frames - f0), 32'd0);
        chk("R10 dout unchanged", 32'(dout), 32'd0);

        // Vector table: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < 6; i++) begin
            set_words(VEC[i]);
            pulse_start();
            chk("R2 cs_n low after start", 32'(cs_n), 32'd0);
            wait_ready("R6 ready timeout");
            chk("R4 R5 sample words", 32'(dout), 32'(VEC[i][23:0]));
            chk("R6 cs_n high with ready", 32'(cs_n), 32'd1);
            held = dout;
            @(negedge clk);
            chk("R6 ready one cycle", 32'(ready), 32'd0);
            chk("R3 frame low length", 32'(last_low), 32'(FRAME_LOW));
            chk("R2 sclk rising edges", 32'(last_rises), 32'd16);
            repeat (20) @(negedge clk);
            chk("R7 dout held", 32'(dout), 32'(held));
        end

        // R9 R8: requests during frame and quiet time merge into one frame
        set_words(VEC[1]);
        f0 = frames;
        pulse_start();
        repeat (40) @(negedge clk);
        pulse_start();
        pulse_start();
        wait_ready("R9 first frame timeout");
        chk("R9 first frame data", 32'(dout), 32'(VEC[1][23:0]));
        set_words(VEC[5]);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        wait_ready("R9 held request not served");
        chk("R9 second frame data", 32'(dout), 32'(VEC[5][23:0]));
        @(negedge clk);
        chk("R8 quiet at least QUIET", 32'(last_hi >= QUIET), 32'd1);
        chk("R9 served right after quiet", 32'(last_hi <= QUIET + 2), 32'd1);
        repeat (400) @(negedge clk);
        chk("R9 requests merged", 32'(frames - f0), 32'd2);

        // R1: reset in mid frame clears everything and drops the request
        set_words(VEC[3]);
        pulse_start();
        repeat (30) @(negedge clk);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 cs_n after mid reset", 32'(cs_n), 32'd1);
        chk("R1 sclk after mid reset", 32'(sclk), 32'd1);
        chk("R1 dout after mid reset", 32'(dout), 32'd0);
        rst_n = 1'b1;
        repeat (400) @(negedge clk);
        chk("R1 no frame after reset", 32'(cs_n), 32'd1);
        chk("R1 dout still cleared", 32'(dout), 32'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule